// File: doc/BRIEF.md
# Two's Complement Adder/Subtractor with Range Classification

This block is a combinational two's complement adder/subtractor of parameterised width, four bits by default. A single select line chooses the operation. When the select is low the block adds the two operands. When it is high the block subtracts the second operand from the first. Subtraction is done by inverting the second operand and forcing the carry into the least significant position to one, so one carry chain serves both operations.

Besides the wrapped result and the carry out of the top bit, the block sorts every result into one of three mutually exclusive range classes. The first class, "too positive", covers results above the largest representable value. The second, "too negative", covers results below the smallest representable value. The third, "in range", covers everything else.

The classification compares the carry entering the most significant bit with the carry leaving it. When they differ, the sign bit of the wrapped result shows the direction of the error. A set sign bit means two non-negative quantities produced a negative pattern, which is positive overflow. A clear sign bit means negative underflow.

Top module: `twos_addsub`

## Requirements
- R1: With `sub_sel_i` = 0, `sum_o` equals (`opa_i` + `opb_i`) modulo 2^W.
- R2: With `sub_sel_i` = 1, `sum_o` equals (`opa_i` - `opb_i`) modulo 2^W. For W = 4: $D - $F gives $E, and $D + $F gives $C.
- R3: `carry_o` is the carry out of the top bit of the sum `opa_i` + `opb_i` + 0 when adding. When subtracting it is the carry out of `opa_i` + ~`opb_i` + 1, which is 1 exactly when `opa_i` >= `opb_i` as unsigned values.
- R4: Exactly one of `pos_ovf_o`, `neg_unf_o` and `in_range_o` is 1 for every input.
- R5: `pos_ovf_o` is 1 exactly when the true signed result exceeds 2^(W-1)-1. For W = 4: $6 + $4 and $7 - $A raise it.
- R6: `neg_unf_o` is 1 exactly when the true signed result is below -2^(W-1). For W = 4: $8 + $F, $D - $7 and $8 - $1 raise it.
- R7: `in_range_o` is 1 exactly when the true signed result lies in -2^(W-1) .. 2^(W-1)-1. For W = 4: $F + $F, $7 + $A and $F - $F are in range.
- R8: The parameter W (at least 2) sets the width of the operands and the result, and R1 to R7 hold for every width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | First operand (minuend when subtracting), two's complement |
| opb_i | input | W | Second operand (subtrahend when subtracting), two's complement |
| sub_sel_i | input | 1 | 0 = add, 1 = subtract |
| sum_o | output | W | Wrapped result |
| carry_o | output | 1 | Carry out of the most significant bit |
| pos_ovf_o | output | 1 | Result above the representable range |
| neg_unf_o | output | 1 | Result below the representable range |
| in_range_o | output | 1 | Result representable |

## Verification
The bench builds two instances of the block. The first uses W = 4, the default. The second uses W = 8, which checks that the carry chain and the range classes scale with the parameter.

Both widths are driven through every combination of operands and operation: 512 vectors at four bits and 131072 at eight. Each result is compared against an integer model that evaluates the exact signed result and classifies it against the range of the width. This exhaustive sweep reaches every boundary. That includes the most negative operand negated, zero minus the most negative value, and sums that land exactly on the range limits.

// File: rtl/twos_addsub_pkg.sv
package twos_addsub_pkg;

  // Range class of one result; exactly one member is set.
  typedef struct packed {
    logic pos_ovf;
    logic neg_unf;
    logic in_range;
  } range_class_t;

endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond #(
  parameter int W = 4
) (
  input  logic [W-1:0] opb_i,
  input  logic         sub_sel_i,
  output logic [W-1:0] opb_eff_o,
  output logic         cin_o
);

  // Subtraction feeds the one's complement and a forced carry-in.
  always_comb begin
    opb_eff_o = opb_i ^ {W{sub_sel_i}};
    cin_o     = sub_sel_i;
  end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_into_msb_o,
  output logic         c_out_o
);

  localparam int MSB = W - 1;

  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    logic g;
    always_comb begin
      p            = a_i[i] ^ b_i[i];
      g            = a_i[i] & b_i[i];
      sum_o[i]     = p ^ chain[i];
      chain[i+1]   = g | (p & chain[i]);
    end
  end

  assign c_into_msb_o = chain[MSB];
  assign c_out_o      = chain[W];

endmodule

// File: rtl/addsub_range_class.sv
module addsub_range_class
  import twos_addsub_pkg::*;
(
  input  logic         c_into_msb_i,
  input  logic         c_out_i,
  input  logic         sum_msb_i,
  output range_class_t cls_o
);

  logic err;

  always_comb begin
    err            = c_into_msb_i ^ c_out_i;
    cls_o.pos_ovf  = err & sum_msb_i;
    cls_o.neg_unf  = err & ~sum_msb_i;
    cls_o.in_range = ~err;
  end

endmodule

// File: rtl/twos_addsub.sv
module twos_addsub
  import twos_addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         sub_sel_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         pos_ovf_o,
  output logic         neg_unf_o,
  output logic         in_range_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] opb_eff;
  logic         cin;
  logic         c_into_msb;
  logic         c_out;
  logic [W-1:0] sum_int;
  range_class_t cls;

  addsub_operand_cond #(.W(W)) u_cond (
    .opb_i     (opb_i),
    .sub_sel_i (sub_sel_i),
    .opb_eff_o (opb_eff),
    .cin_o     (cin)
  );

  addsub_ripple #(.W(W)) u_ripple (
    .a_i          (opa_i),
    .b_i          (opb_eff),
    .cin_i        (cin),
    .sum_o        (sum_int),
    .c_into_msb_o (c_into_msb),
    .c_out_o      (c_out)
  );

  addsub_range_class u_class (
    .c_into_msb_i (c_into_msb),
    .c_out_i      (c_out),
    .sum_msb_i    (sum_int[MSB]),
    .cls_o        (cls)
  );

  assign sum_o      = sum_int;
  assign carry_o    = c_out;
  assign pos_ovf_o  = cls.pos_ovf;
  assign neg_unf_o  = cls.neg_unf;
  assign in_range_o = cls.in_range;

endmodule

// File: rtl/twos_addsub_chk.sv
module twos_addsub_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         sub_sel_i,
  input logic [W-1:0] sum_o,
  input logic         carry_o,
  input logic         pos_ovf_o,
  input logic         neg_unf_o,
  input logic         in_range_o
);

  localparam int MSB = W - 1;

  logic a_s;
  logic b_s;
  logic r_s;
  logic b_eff_s;

  always_comb begin
    a_s     = opa_i[MSB];
    b_s     = opb_i[MSB];
    r_s     = sum_o[MSB];
    b_eff_s = b_s ^ sub_sel_i;

    // R4: the three classes are mutually exclusive and cover all inputs
    p_one_class_r4: assert ($countones({pos_ovf_o, neg_unf_o, in_range_o}) == 1)
      else $error("one-class violated");

    // R5: positive overflow only from two non-negative effective operands yielding a negative pattern
    p_pos_ovf_signs_r5: assert (!pos_ovf_o || (!a_s && !b_eff_s && r_s))
      else $error("pos overflow sign pattern");

    // R6: negative underflow only from two negative effective operands yielding a non-negative pattern
    p_neg_unf_signs_r6: assert (!neg_unf_o || (a_s && b_eff_s && !r_s))
      else $error("neg underflow sign pattern");

    // R7: operands of effective opposite sign never leave the range
    p_mixed_in_range_r7: assert ((a_s == b_eff_s) || in_range_o)
      else $error("mixed signs out of range");

    // R2: result plus subtrahend gives back the minuend
    p_sub_inverse_r2: assert (!sub_sel_i || (W'(sum_o + opb_i) == opa_i))
      else $error("subtract inverse");

    // R3: subtract carry equals unsigned no-borrow
    p_sub_carry_r3: assert (!sub_sel_i || (carry_o == (opa_i >= opb_i)))
      else $error("subtract carry");
  end

endmodule

bind twos_addsub twos_addsub_chk #(.W(W)) u_twos_addsub_chk (
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .sub_sel_i  (sub_sel_i),
  .sum_o      (sum_o),
  .carry_o    (carry_o),
  .pos_ovf_o  (pos_ovf_o),
  .neg_unf_o  (neg_unf_o),
  .in_range_o (in_range_o)
);

// File: tb/test_twos_addsub.sv
module test_twos_addsub;

  logic clk;
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests;
  int n_fail;
  bit done;

  // width-4 instance
  logic [3:0] a4, b4, s4;
  logic       sub4, c4, ov4, un4, ok4;
  // width-8 instance
  logic [7:0] a8, b8, s8;
  logic       sub8, c8, ov8, un8, ok8;

  twos_addsub #(.W(4)) i_twos_addsub (
    .opa_i(a4), .opb_i(b4), .sub_sel_i(sub4), .sum_o(s4), .carry_o(c4),
    .pos_ovf_o(ov4), .neg_unf_o(un4), .in_range_o(ok4)
  );

  twos_addsub #(.W(8)) i_twos_addsub_w8 (
    .opa_i(a8), .opb_i(b8), .sub_sel_i(sub8), .sum_o(s8), .carry_o(c8),
    .pos_ovf_o(ov8), .neg_unf_o(un8), .in_range_o(ok8)
  );

  function automatic int to_signed(int v, int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  task automatic check_one(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Compares one vector of any width against the integer model.
  task automatic check_vec(int w, int a, int b, int sub, int sum, int cy,
                           int ov, int un, int ok);
    int mask, exact, lo, hi, esum, ecy;
    string ctx;
    mask  = (1 << w) - 1;
    exact = sub ? to_signed(a, w) - to_signed(b, w) : to_signed(a, w) + to_signed(b, w);
    hi    = (1 << (w - 1)) - 1;
    lo    = -(1 << (w - 1));
    esum  = (sub ? a - b : a + b) & mask;
    ecy   = sub ? ((a + (~b & mask) + 1) >> w) & 1 : ((a + b) >> w) & 1;
    ctx   = $sformatf("w=%0d a=%0h b=%0h sub=%0d", w, a, b, sub);
    if (w == 8) check_one({"R8 ", ctx}, sum, esum);
    check_one({sub ? "R2 sum " : "R1 sum ", ctx}, sum, esum);
    check_one({"R3 carry ", ctx}, cy, ecy);
    check_one({"R4 onehot ", ctx}, ov + un + ok, 1);
    check_one({"R5 pos_ovf ", ctx}, ov, int'(exact > hi));
    check_one({"R6 neg_unf ", ctx}, un, int'(exact < lo));
    check_one({"R7 in_range ", ctx}, ok, int'(exact >= lo && exact <= hi));
  endtask

  task automatic apply4(int a, int b, int sub);
    a4 = 4'(a); b4 = 4'(b); sub4 = sub[0];
    #1;
    check_vec(4, a, b, sub, int'(s4), int'(c4), int'(ov4), int'(un4), int'(ok4));
    #1;
  endtask

  task automatic apply8(int a, int b, int sub);
    a8 = 8'(a); b8 = 8'(b); sub8 = sub[0];
    #1;
    check_vec(8, a, b, sub, int'(s8), int'(c8), int'(ov8), int'(un8), int'(ok8));
    #1;
  endtask

  // Worked vectors with known results at width 4 (R2, R5, R6, R7).
  task automatic test_known_vectors();
    apply4(4'hD, 4'hF, 0); check_one("R1 $D+$F", int'(s4), 4'hC);
    apply4(4'hD, 4'hF, 1); check_one("R2 $D-$F", int'(s4), 4'hE);
    apply4(4'h6, 4'h4, 0); check_one("R5 $6+$4", int'(ov4), 1);
    apply4(4'h8, 4'hF, 0); check_one("R6 $8+$F", int'(un4), 1);
    apply4(4'hF, 4'hF, 0); check_one("R7 $F+$F", int'(ok4), 1);
    apply4(4'h7, 4'hA, 0); check_one("R7 $7+$A", int'(ok4), 1);
    apply4(4'hD, 4'h7, 1); check_one("R6 $D-$7", int'(un4), 1);
    apply4(4'h7, 4'hA, 1); check_one("R5 $7-$A", int'(ov4), 1);
    apply4(4'h8, 4'h1, 1); check_one("R6 $8-$1", int'(un4), 1);
    apply4(4'hF, 4'hF, 1); check_one("R7 $F-$F sum", int'(s4), 0);
  endtask

  task automatic test_sweep_w4();
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply4(a, b, s);
  endtask

  task automatic test_sweep_w8();
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          apply8(a, b, s);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    a4 = '0; b4 = '0; sub4 = 1'b0;
    a8 = '0; b8 = '0; sub8 = 1'b0;
    #1;
    check_one("R7 idle in_range", int'(ok4), 1);
    check_one("R1 idle sum", int'(s4), 0);
    test_known_vectors();
    test_sweep_w4();
    test_sweep_w8();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule